// File: doc/BRIEF.md
# BCD calendar clock counter

This block keeps wall-clock time and calendar date as packed BCD bytes for seconds, minutes, hours (24-hour, 00 to 23), day of week, date, month, year and century. An oscillator tick input, nominally 32768 Hz, feeds a binary prescaler. When the prescaler wraps it produces the one-second enable that advances the counter chain. Month lengths follow the calendar. February gains a 29th day whenever the two-digit year is a multiple of four.

A host interface presets every field at once through a parallel load port and reads every field at all times through a parallel read-out. Two control bits sit inside the time bytes. Bit 7 of the seconds byte stops the oscillator count. Bit 6 of the day-of-week byte selects a test mode, in which the seconds LSB on the read-out follows a fast prescaler bit so that the oscillator rate can be measured.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the read-out shows seconds 00, minutes 00, hours 00, day of week 01, date 01, month 01, year 00 and century 20. The prescaler starts at zero, the stop bit is 0 and the test bit is 0.
- R2: Every cycle with `osc_tick` high and the stop bit clear advances the prescaler by one. Cycles with `osc_tick` low leave it unchanged. Seconds advance on the tick that takes the prescaler from 2^PRE_W-1 back to 0, so the first advance after a load comes on exactly the 2^PRE_W-th tick.
- R3: Seconds and minutes count 00 to 59 in BCD and hours count 00 to 23. Each field wraps to 00 and carries into the next field on the same clock edge.
- R4: The day of week counts 1 to 7 and steps on each midnight carry from the hours field. From 7 it wraps to 1, regardless of the date.
- R5: The date wraps to 01 and advances the month after day 31 in months 01, 03, 05, 07, 08, 10 and 12, and after day 30 in months 04, 06, 09 and 11. The month wraps from 12 to 01.
- R6: February ends after day 29 when the BCD year is a multiple of four, with year 00 counted as leap, and after day 28 otherwise.
- R7: When the year wraps from 99 to 00, the century BCD increments on the same edge. The century itself wraps from 99 to 00.
- R8: While seconds-byte bit 7 (the stop bit) is 1, the prescaler and every time field hold their values whatever `osc_tick` does. The stop bit reads back as bit 7 of `rd_sec`.
- R9: When day-byte bit 6 (the test bit) is 1 and the stop bit is 0, bit 0 of `rd_sec` shows prescaler bit TEST_BIT. That bit toggles every 2^TEST_BIT ticks, which is 512 Hz at the default parameters. In every other case bit 0 of `rd_sec` is the stored seconds LSB.
- R10: A cycle with `load_stb` high copies every load byte into the counters and clears the prescaler. The load takes priority over counting in that cycle.
- R11: Load bits that hold no field are dropped and read back as 0. These bits are minutes bit 7, hours bits 7:6, day bits 7 and 5:3, date bits 7:6 and month bits 7:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| load_stb | input | 1 | Loads all fields and clears the prescaler |
| ld_sec | input | 8 | Stop bit (7) and BCD seconds (6:0) |
| ld_min | input | 8 | BCD minutes (6:0) |
| ld_hour | input | 8 | BCD hours (5:0) |
| ld_dow | input | 8 | Test bit (6) and day of week (2:0) |
| ld_date | input | 8 | BCD date (5:0) |
| ld_month | input | 8 | BCD month (4:0) |
| ld_year | input | 8 | BCD year |
| ld_cent | input | 8 | BCD century |
| rd_sec | output | 8 | Stop bit and BCD seconds, with the LSB replaced in test mode |
| rd_min | output | 8 | BCD minutes |
| rd_hour | output | 8 | BCD hours |
| rd_dow | output | 8 | Test bit and day of week |
| rd_date | output | 8 | BCD date |
| rd_month | output | 8 | BCD month |
| rd_year | output | 8 | BCD year |
| rd_cent | output | 8 | BCD century |

## Verification
The range properties assume that every load carries a real calendar moment. This means legal BCD digits, fields inside their ranges, a day of week from 1 to 7 and a date no later than the last day of its month in the loaded year. The bench draws each random load as binary values inside those limits and then converts them to BCD. To bias toward rollovers, it often picks the last second, minute, hour or day of the month. The directed cases load the month-end, February and century boundaries by hand. Every directed load uses legal values, including the one that sets the unused load bits.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic       stop;
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic       ftest;
        logic [2:0] dow;
        logic [5:0] date;
        logic [4:0] month;
        logic [7:0] year;
        logic [7:0] cent;
    } cal_t;

    // Two-digit BCD year divisible by four (00 counts as leap).
    function automatic logic year_is_leap(input logic [7:0] y);
        logic [3:0] ones;
        ones = y[3:0];
        if (y[4])
            year_is_leap = (ones == 4'd2) || (ones == 4'd6);
        else
            year_is_leap = (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
    endfunction

    // Last day of the month, in BCD.
    function automatic logic [5:0] month_days(input logic [4:0] m, input logic [7:0] y);
        case (m)
            5'h02:                      month_days = year_is_leap(y) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: month_days = 6'h30;
            default:                    month_days = 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRE_W    = 15,
    parameter int TEST_BIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic run_i,
    input  logic clr_i,
    output logic roll_o,
    output logic phase_o
);
    localparam logic [PRE_W-1:0] TOP = {PRE_W{1'b1}};

    logic [PRE_W-1:0] cnt_q, cnt_d;
    logic             step;

    assign step = tick_i && run_i;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (step)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign roll_o  = step && !clr_i && (cnt_q == TOP);
    assign phase_o = cnt_q[TEST_BIT];

    // R2
    roll_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        roll_o |=> (cnt_q == '0));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !clr_i) |=> $stable(cnt_q));

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/rtc_bcd_wrap.sv
module rtc_bcd_wrap #(
    parameter int W = 8
) (
    input  logic         en_i,
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] hi_i,
    output logic [W-1:0] nxt_o,
    output logic         wrap_o
);
    logic [W-1:0] inc;

    always_comb begin
        if (cur_i[3:0] == 4'd9)
            inc = {cur_i[W-1:4] + 1'b1, 4'd0};
        else
            inc = {cur_i[W-1:4], cur_i[3:0] + 4'd1};
    end

    assign wrap_o = en_i && (cur_i >= hi_i);
    assign nxt_o  = !en_i ? cur_i : (wrap_o ? lo_i : inc);

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
    import rtc_pkg::*;
#(
    parameter int PRE_W    = 15,
    parameter int TEST_BIT = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       load_stb,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hour,
    input  logic [7:0] ld_dow,
    input  logic [7:0] ld_date,
    input  logic [7:0] ld_month,
    input  logic [7:0] ld_year,
    input  logic [7:0] ld_cent,
    output logic [7:0] rd_sec,
    output logic [7:0] rd_min,
    output logic [7:0] rd_hour,
    output logic [7:0] rd_dow,
    output logic [7:0] rd_date,
    output logic [7:0] rd_month,
    output logic [7:0] rd_year,
    output logic [7:0] rd_cent
);
    localparam cal_t RESET_VAL = '{stop: 1'b0, sec: 7'h00, min: 7'h00, hour: 6'h00,
                                   ftest: 1'b0, dow: 3'd1, date: 6'h01, month: 5'h01,
                                   year: 8'h00, cent: 8'h20};

    cal_t st_q, st_d;

    logic       sec_en, test_phase;
    logic [6:0] sec_n, min_n;
    logic [5:0] hour_n, date_n;
    logic [4:0] month_n;
    logic [7:0] year_n, cent_n;
    logic [2:0] dow_n;
    logic       sec_w, min_w, hour_w, date_w, month_w, year_w, cent_w_unused;
    logic [5:0] last_day;
    logic       unused_ld_bits;

    assign unused_ld_bits = ^{ld_min[7], ld_hour[7:6], ld_dow[7], ld_dow[5:3],
                              ld_date[7:6], ld_month[7:5], cent_w_unused};

    rtc_prescaler #(.PRE_W(PRE_W), .TEST_BIT(TEST_BIT)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (osc_tick),
        .run_i   (!st_q.stop),
        .clr_i   (load_stb),
        .roll_o  (sec_en),
        .phase_o (test_phase)
    );

    assign last_day = month_days(st_q.month, st_q.year);

    rtc_bcd_wrap #(.W(7)) u_sec (
        .en_i(sec_en), .cur_i(st_q.sec), .lo_i(7'h00), .hi_i(7'h59),
        .nxt_o(sec_n), .wrap_o(sec_w));

    rtc_bcd_wrap #(.W(7)) u_min (
        .en_i(sec_w), .cur_i(st_q.min), .lo_i(7'h00), .hi_i(7'h59),
        .nxt_o(min_n), .wrap_o(min_w));

    rtc_bcd_wrap #(.W(6)) u_hour (
        .en_i(min_w), .cur_i(st_q.hour), .lo_i(6'h00), .hi_i(6'h23),
        .nxt_o(hour_n), .wrap_o(hour_w));

    rtc_bcd_wrap #(.W(6)) u_date (
        .en_i(hour_w), .cur_i(st_q.date), .lo_i(6'h01), .hi_i(last_day),
        .nxt_o(date_n), .wrap_o(date_w));

    rtc_bcd_wrap #(.W(5)) u_month (
        .en_i(date_w), .cur_i(st_q.month), .lo_i(5'h01), .hi_i(5'h12),
        .nxt_o(month_n), .wrap_o(month_w));

    rtc_bcd_wrap #(.W(8)) u_year (
        .en_i(month_w), .cur_i(st_q.year), .lo_i(8'h00), .hi_i(8'h99),
        .nxt_o(year_n), .wrap_o(year_w));

    rtc_bcd_wrap #(.W(8)) u_cent (
        .en_i(year_w), .cur_i(st_q.cent), .lo_i(8'h00), .hi_i(8'h99),
        .nxt_o(cent_n), .wrap_o(cent_w_unused));

    // Day of week runs on its own 1..7 ring, stepped by the midnight carry.
    always_comb begin
        dow_n = st_q.dow;
        if (hour_w)
            dow_n = (st_q.dow >= 3'd7) ? 3'd1 : st_q.dow + 3'd1;
    end

    always_comb begin
        st_d = st_q;
        if (load_stb) begin
            st_d.stop  = ld_sec[7];
            st_d.sec   = ld_sec[6:0];
            st_d.min   = ld_min[6:0];
            st_d.hour  = ld_hour[5:0];
            st_d.ftest = ld_dow[6];
            st_d.dow   = ld_dow[2:0];
            st_d.date  = ld_date[5:0];
            st_d.month = ld_month[4:0];
            st_d.year  = ld_year;
            st_d.cent  = ld_cent;
        end else begin
            st_d.sec   = sec_n;
            st_d.min   = min_n;
            st_d.hour  = hour_n;
            st_d.dow   = dow_n;
            st_d.date  = date_n;
            st_d.month = month_n;
            st_d.year  = year_n;
            st_d.cent  = cent_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RESET_VAL;
        else        st_q <= st_d;
    end

    logic test_on;
    assign test_on = st_q.ftest && !st_q.stop;

    assign rd_sec   = {st_q.stop, st_q.sec[6:1], test_on ? test_phase : st_q.sec[0]};
    assign rd_min   = {1'b0, st_q.min};
    assign rd_hour  = {2'b00, st_q.hour};
    assign rd_dow   = {1'b0, st_q.ftest, 3'b000, st_q.dow};
    assign rd_date  = {2'b00, st_q.date};
    assign rd_month = {3'b000, st_q.month};
    assign rd_year  = st_q.year;
    assign rd_cent  = st_q.cent;

    // R3
    clock_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sec <= 7'h59) && (st_q.min <= 7'h59) && (st_q.hour <= 6'h23));

    // R4
    dow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dow >= 3'd1) && (st_q.dow <= 3'd7));

    // R5 R6
    date_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.date >= 6'h01) && (st_q.date <= last_day));

    // R7
    century_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_stb && year_w) |=> (st_q.year == 8'h00) && (st_q.cent != $past(st_q.cent)));

    // R8
    stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stop && !load_stb) |=> $stable(st_q));

    // R10
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> (rd_min == {1'b0, $past(ld_min[6:0])}) && (rd_year == $past(ld_year))
                     && (rd_cent == $past(ld_cent)) && (st_q.stop == $past(ld_sec[7])));

endmodule

// File: tb/sim_bcd_calendar_clock.sv
`timescale 1ns/1ps
module sim_bcd_calendar_clock;
    localparam int PW = 6;
    localparam int TB = 5;
    localparam int PRE_MOD = 1 << PW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_tick = 1'b0;
    logic load_stb = 1'b0;
    logic [7:0] ld_sec = '0, ld_min = '0, ld_hour = '0, ld_dow = '0;
    logic [7:0] ld_date = '0, ld_month = '0, ld_year = '0, ld_cent = '0;
    logic [7:0] rd_sec, rd_min, rd_hour, rd_dow, rd_date, rd_month, rd_year, rd_cent;

    always #4 clk = ~clk;

    bcd_calendar_clock #(.PRE_W(PW), .TEST_BIT(TB)) u0 (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .load_stb(load_stb),
        .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_dow(ld_dow),
        .ld_date(ld_date), .ld_month(ld_month), .ld_year(ld_year), .ld_cent(ld_cent),
        .rd_sec(rd_sec), .rd_min(rd_min), .rd_hour(rd_hour), .rd_dow(rd_dow),
        .rd_date(rd_date), .rd_month(rd_month), .rd_year(rd_year), .rd_cent(rd_cent));

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Bench model, binary values
    int m_sec, m_min, m_hour, m_dow, m_date, m_month, m_year, m_cent, m_pre;
    bit m_stop, m_ft;

    function automatic logic [7:0] bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int days_in(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_second();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hour++;
                if (m_hour == 24) begin
                    m_hour = 0;
                    m_dow = (m_dow == 7) ? 1 : m_dow + 1;
                    m_date++;
                    if (m_date > days_in(m_month, m_year)) begin
                        m_date = 1; m_month++;
                        if (m_month == 13) begin
                            m_month = 1; m_year++;
                            if (m_year == 100) begin
                                m_year = 0;
                                m_cent = (m_cent + 1) % 100;
                            end
                        end
                    end
                end
            end
        end
    endtask

    task automatic set_time(input int ce, input int yr, input int mo, input int da,
                            input int dw, input int hr, input int mi, input int se,
                            input bit stp, input bit ft, input bit junk);
        @(negedge clk);
        ld_sec   = {stp, bcd(se)[6:0]};
        ld_min   = {junk, bcd(mi)[6:0]};
        ld_hour  = {{2{junk}}, bcd(hr)[5:0]};
        ld_dow   = {junk, ft, {3{junk}}, 3'(dw)};
        ld_date  = {{2{junk}}, bcd(da)[5:0]};
        ld_month = {{3{junk}}, bcd(mo)[4:0]};
        ld_year  = bcd(yr);
        ld_cent  = bcd(ce);
        load_stb = 1'b1;
        @(negedge clk);
        load_stb = 1'b0;
        m_cent = ce; m_year = yr; m_month = mo; m_date = da; m_dow = dw;
        m_hour = hr; m_min = mi; m_sec = se; m_stop = stp; m_ft = ft; m_pre = 0;
    endtask

    task automatic run_ticks(input int n, input int max_gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            osc_tick = 1'b1;
            @(negedge clk);
            osc_tick = 1'b0;
            if (!m_stop) begin
                m_pre++;
                if (m_pre == PRE_MOD) begin
                    m_pre = 0;
                    model_second();
                end
            end
            if (max_gap > 0) repeat ($urandom_range(max_gap, 0)) @(negedge clk);
        end
    endtask

    task automatic check_all(input string tag);
        logic [7:0] e_sec;
        logic [63:0] exp_v, act_v;
        e_sec = {m_stop, bcd(m_sec)[6:0]};
        if (m_ft && !m_stop) e_sec[0] = 1'((m_pre >> TB) & 1);
        exp_v = {e_sec, bcd(m_min), bcd(m_hour), {1'b0, m_ft, 3'b000, 3'(m_dow)},
                 bcd(m_date), bcd(m_month), bcd(m_year), bcd(m_cent)};
        act_v = {rd_sec, rd_min, rd_hour, rd_dow, rd_date, rd_month, rd_year, rd_cent};
        n_checks++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp_b);
        n_checks++;
        if (act !== exp_b) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp_b);
        end
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'hC0DE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        m_sec = 0; m_min = 0; m_hour = 0; m_dow = 1; m_date = 1; m_month = 1;
        m_year = 0; m_cent = 20; m_pre = 0; m_stop = 0; m_ft = 0;
        check_all("R1 reset");
        run_ticks(PRE_MOD, 0);
        check_all("R1 R2 first second from reset");

        // R10 load clears prescaler, R2 full second after load
        set_time(20, 25, 6, 12, 3, 12, 30, 15, 0, 0, 0);
        run_ticks(40, 0);
        set_time(20, 25, 6, 12, 3, 12, 30, 15, 0, 0, 0);
        run_ticks(PRE_MOD - 1, 0);
        check_all("R10 prescaler cleared by load");
        run_ticks(1, 0);
        check_all("R2 advance on full count");

        // R3 R4 midnight with day-of-week wrap
        set_time(20, 25, 3, 15, 7, 23, 59, 59, 0, 0, 0);
        run_ticks(PRE_MOD, 0);
        check_all("R3 R4 midnight rollover");

        // R5 month ends
        set_time(20, 25, 4, 30, 2, 23, 59, 59, 0, 0, 0);
        run_ticks(PRE_MOD, 0);
        check_all("R5 thirty-day month end");
        set_time(20, 25, 1, 31, 2, 23, 59, 59, 0, 0, 0);
        run_ticks(PRE_MOD, 0);
        check_all("R5 thirty-one-day month end");

        // R6 February
        set_time(20, 24, 2, 28, 4, 23, 59, 59, 0, 0, 0);
        run_ticks(PRE_MOD, 0);
        check_all("R6 leap Feb 28 to 29");
        set_time(20, 24, 2, 29, 5, 23, 59, 59, 0, 0, 0);
        run_ticks(PRE_MOD, 0);
        check_all("R6 leap Feb 29 to Mar 1");
        set_time(20, 23, 2, 28, 5, 23, 59, 59, 0, 0, 0);
        run_ticks(PRE_MOD, 0);
        check_all("R6 common Feb 28 to Mar 1");
        set_time(21, 0, 2, 28, 1, 23, 59, 59, 0, 0, 0);
        run_ticks(PRE_MOD, 0);
        check_all("R6 year 00 is leap");

        // R7 century
        set_time(20, 99, 12, 31, 6, 23, 59, 59, 0, 0, 0);
        run_ticks(PRE_MOD, 0);
        check_all("R7 year wrap bumps century");
        set_time(99, 99, 12, 31, 6, 23, 59, 59, 0, 0, 0);
        run_ticks(PRE_MOD, 0);
        check_all("R7 century wraps to 00");

        // R8 stop
        set_time(20, 25, 7, 4, 5, 10, 20, 30, 1, 0, 0);
        run_ticks(3 * PRE_MOD, 0);
        check_all("R8 stopped clock holds");
        check_bit("R8 stop bit read-out", rd_sec[7], 1'b1);
        set_time(20, 25, 7, 4, 5, 10, 20, 30, 0, 0, 0);
        run_ticks(PRE_MOD, 0);
        check_all("R8 restart after stop cleared");

        // R9 frequency test
        set_time(20, 25, 7, 4, 5, 10, 20, 10, 0, 1, 0);
        run_ticks(1 << TB, 0);
        check_bit("R9 test LSB high half", rd_sec[0], 1'b1);
        run_ticks(1 << TB, 0);
        check_bit("R9 test LSB low half", rd_sec[0], 1'b0);
        check_all("R9 test mode full read-out");
        set_time(20, 25, 7, 4, 5, 10, 20, 10, 0, 0, 0);
        run_ticks(1 << TB, 0);
        check_bit("R9 test off shows stored LSB", rd_sec[0], 1'b0);
        set_time(20, 25, 7, 4, 5, 10, 20, 10, 1, 1, 0);
        run_ticks(1 << TB, 0);
        check_bit("R9 test with stop shows stored LSB", rd_sec[0], 1'b0);

        // R11 unused load bits dropped
        set_time(20, 25, 8, 9, 3, 11, 59, 5, 0, 0, 1);
        check_all("R11 unused load bits read 0");
        run_ticks(PRE_MOD, 0);
        check_all("R11 counting after junk load");

        // Random loads biased toward boundaries
        for (int t = 0; t < 150; t++) begin
            int ce, yr, mo, da, dw, hr, mi, se, ns;
            ce = ($urandom_range(4, 0) == 0) ? 99 : $urandom_range(99, 0);
            yr = ($urandom_range(2, 0) == 0) ? 99 : $urandom_range(99, 0);
            mo = ($urandom_range(2, 0) == 0) ? (($urandom_range(1, 0) == 0) ? 2 : 12)
                                             : $urandom_range(12, 1);
            da = ($urandom_range(1, 0) == 0) ? days_in(mo, yr) : $urandom_range(days_in(mo, yr), 1);
            dw = $urandom_range(7, 1);
            hr = ($urandom_range(1, 0) == 0) ? 23 : $urandom_range(23, 0);
            mi = ($urandom_range(1, 0) == 0) ? 59 : $urandom_range(59, 0);
            se = ($urandom_range(1, 0) == 0) ? 59 : $urandom_range(59, 0);
            ns = $urandom_range(2, 1);
            set_time(ce, yr, mo, da, dw, hr, mi, se, 0, 0, 0);
            run_ticks(ns * PRE_MOD, 1);
            check_all("R2 R3 R4 R5 R6 R7 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule